// File: doc/BRIEF.md
# Multi-Level Cache Hierarchy Latency Model

This block models the timing of byte reads through a stack of one to three fully associative cache levels that sit in front of main memory. It keeps only tags, valid bits and recency state, with no data. Each level has its own block size, which is a power of two, its own number of block slots and its own access time. A read address comes in over a valid/ready handshake. A small walker then probes the levels from the top down. It installs the enclosing block, at that level's own granularity, in every level that missed, and refreshes recency in the level that hit. At the end it emits a one-cycle result pulse that carries the latency of the request.

The latency of a request is the sum of the access times of every level probed. A request that misses everywhere also pays the main-memory time. A running 32-bit total adds up the latency of every completed request. A start-of-case pulse zeroes the total and, when no walk is in flight, empties every level, so that a new trace can be replayed. The configuration comes in on static input ports. It is changed only together with a start-of-case pulse.

Top module: `cachelat_top`

## Requirements
- R1: `req_ready` is high only while the walker is idle and `start_case` is low. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Each taken request produces exactly one `done_valid` pulse, one cycle long, and `req_ready` stays low until that pulse has passed.
- R2: A request whose block is first found in level k (1-based) reports on `done_lat` the sum of the access times of levels 1 to k.
- R3: A request found in no level reports the sum of all configured level access times plus `cfg_mem_lat`.
- R4: Level i identifies a block by the address shifted right by `cfg_blk_log2[i*4 +: 4]`. Any address inside an aligned block that a level holds hits in that level.
- R5: A fill goes into an empty slot, among the first `cfg_blocks` slots of the level, whenever one exists. No resident block is evicted while a free slot remains.
- R6: When a level is full, a fill replaces the block of that level that was least recently touched.
- R7: A hit makes the hitting block the most recently used of its level, without a fill.
- R8: Every level that missed during a walk holds the requested block afterwards. A later read of the same block therefore hits at level 1.
- R9: `total_lat` adds each `done_lat` on its pulse cycle. `start_case` zeroes `total_lat` on the next edge and takes priority over an addition in the same cycle. When `start_case` is raised while the walker is idle or on the `done_valid` cycle, it also empties every level.
- R10: `cfg_levels` (1, 2 or 3) sets how many levels are probed before main memory.
- R11: After reset all levels are empty, `total_lat` is 0, `done_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_case | input | 1 | Start of a new trace: clear the total and, when idle or on done, empty the levels |
| cfg_levels | input | 2 | Number of cache levels in use, 1 to 3 |
| cfg_blk_log2 | input | 12 | log2 of the block size per level, 4 bits per level, level 1 in the low bits |
| cfg_blocks | input | 3*CNT_W | Number of block slots in use per level, CNT_W bits each |
| cfg_lat | input | 3*LAT_W | Access time per level, LAT_W bits each |
| cfg_mem_lat | input | LAT_W | Main-memory access time |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Walker can take a request |
| req_addr | input | 16 | Byte address of the read |
| done_valid | output | 1 | One-cycle result pulse |
| done_lat | output | LAT_W+2 | Latency of the finished request |
| total_lat | output | TOT_W | Running sum of latencies |

## Verification
The accumulator can receive an addition and a clear in the same cycle, when `start_case` coincides with the `done_valid` pulse of a finishing request. The bench raises `start_case` exactly on the cycle where it sees the pulse. It then expects `total_lat` to read zero, not the added latency. The next read of the same address must miss in every level, which shows that the levels were emptied on that cycle as well.

// File: rtl/cachelat_pkg.sv
package cachelat_pkg;
    localparam int ADDR_W = 16;
    localparam int SH_W   = 4;
    localparam int LEVELS = 3;
    localparam int LVL_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_FILL,
        ST_MEMORY,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LVL_W-1:0]  lvl;
    } walk_ctx_t;

    function automatic logic [ADDR_W-1:0] block_tag(input logic [ADDR_W-1:0] a,
                                                    input logic [SH_W-1:0]   sh);
        return a >> sh;
    endfunction
endpackage

// File: rtl/cachelat_level.sv
module cachelat_level
    import cachelat_pkg::*;
#(
    parameter int MAX_BLOCKS = 8,
    parameter int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [SH_W-1:0]   cfg_shift,
    input  logic [ADDR_W-1:0] addr,
    input  logic              touch_en,
    input  logic              fill_en,
    output logic              hit
);
    localparam int IDX_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1;
    localparam int AGE_W = IDX_W + 1;

    logic [ADDR_W-1:0]     tag_q [MAX_BLOCKS];
    logic [AGE_W-1:0]      age_q [MAX_BLOCKS];
    logic [MAX_BLOCKS-1:0] valid_q;
    logic [MAX_BLOCKS-1:0] in_range;
    logic [MAX_BLOCKS-1:0] hit_vec;
    logic [ADDR_W-1:0]     cur_tag;
    logic [IDX_W-1:0]      hit_idx, free_idx, vict_idx, fill_idx;
    logic [AGE_W-1:0]      hit_age, vict_age;
    logic                  free_found;

    assign cur_tag = block_tag(addr, cfg_shift);

    always_comb begin
        for (int i = 0; i < MAX_BLOCKS; i++) begin
            in_range[i] = (i < int'(cfg_count));
        end
    end

    always_comb begin
        hit_vec    = '0;
        hit_idx    = '0;
        hit_age    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        vict_idx   = '0;
        vict_age   = '0;
        for (int i = 0; i < MAX_BLOCKS; i++) begin
            hit_vec[i] = in_range[i] && valid_q[i] && (tag_q[i] == cur_tag);
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
                hit_age = age_q[i];
            end
            if (in_range[i] && !valid_q[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (in_range[i] && valid_q[i] && (age_q[i] >= vict_age)) begin
                vict_age = age_q[i];
                vict_idx = IDX_W'(i);
            end
        end
        fill_idx = free_found ? free_idx : vict_idx;
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
            for (int i = 0; i < MAX_BLOCKS; i++) age_q[i] <= '0;
        end else if (touch_en && hit) begin
            for (int i = 0; i < MAX_BLOCKS; i++) begin
                if (IDX_W'(i) == hit_idx)                 age_q[i] <= '0;
                else if (valid_q[i] && age_q[i] < hit_age) age_q[i] <= age_q[i] + 1'b1;
            end
        end else if (fill_en) begin
            for (int i = 0; i < MAX_BLOCKS; i++) begin
                if (IDX_W'(i) == fill_idx) begin
                    valid_q[i] <= 1'b1;
                    age_q[i]   <= '0;
                end else if (valid_q[i]) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !rst && !flush) tag_q[fill_idx] <= cur_tag;
    end

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> hit); // R8
    AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !hit); // R5
    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_vec) <= 1); // R4
endmodule

// File: rtl/cachelat_total.sv
module cachelat_total #(
    parameter int IN_W  = 18,
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             add_en,
    input  logic [IN_W-1:0]  add_val,
    output logic [TOT_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (rst || clear) total <= '0;
        else if (add_en)  total <= total + TOT_W'(add_val);
    end
endmodule

// File: rtl/cachelat_top.sv
module cachelat_top
    import cachelat_pkg::*;
#(
    parameter int MAX_BLOCKS = 8,
    parameter int LAT_W      = 16,
    parameter int TOT_W      = 32,
    parameter int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_case,
    input  logic [LVL_W-1:0]        cfg_levels,
    input  logic [LEVELS*SH_W-1:0]  cfg_blk_log2,
    input  logic [LEVELS*CNT_W-1:0] cfg_blocks,
    input  logic [LEVELS*LAT_W-1:0] cfg_lat,
    input  logic [LAT_W-1:0]        cfg_mem_lat,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    done_valid,
    output logic [LAT_W+1:0]        done_lat,
    output logic [TOT_W-1:0]        total_lat
);
    localparam int SUM_W = LAT_W + 2;

    walk_state_e       state_q;
    walk_ctx_t         ctx_q;
    logic [SUM_W-1:0]  lat_q;
    logic [LVL_W-1:0]  last_lvl;
    logic [LEVELS-1:0] lvl_hit;
    logic [LAT_W-1:0]  lat_sel;
    logic              flush;

    assign last_lvl  = (cfg_levels == '0) ? '0 : cfg_levels - 1'b1;
    assign lat_sel   = cfg_lat[ctx_q.lvl*LAT_W +: LAT_W];
    assign req_ready = (state_q == ST_IDLE) && !start_case;
    assign flush     = start_case && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        cachelat_level #(.MAX_BLOCKS(MAX_BLOCKS), .CNT_W(CNT_W)) level_i (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .cfg_count (cfg_blocks[g*CNT_W +: CNT_W]),
            .cfg_shift (cfg_blk_log2[g*SH_W +: SH_W]),
            .addr      (ctx_q.addr),
            .touch_en  ((state_q == ST_PROBE) && (ctx_q.lvl == LVL_W'(g))),
            .fill_en   ((state_q == ST_FILL)  && (ctx_q.lvl == LVL_W'(g))),
            .hit       (lvl_hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            lat_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid && req_ready) begin
                    ctx_q.addr <= req_addr;
                    ctx_q.lvl  <= '0;
                    lat_q      <= '0;
                    state_q    <= ST_PROBE;
                end
                ST_PROBE: begin
                    lat_q   <= lat_q + SUM_W'(lat_sel);
                    state_q <= lvl_hit[ctx_q.lvl] ? ST_DONE : ST_FILL;
                end
                ST_FILL: begin
                    if (ctx_q.lvl == last_lvl) begin
                        state_q <= ST_MEMORY;
                    end else begin
                        ctx_q.lvl <= ctx_q.lvl + 1'b1;
                        state_q   <= ST_PROBE;
                    end
                end
                ST_MEMORY: begin
                    lat_q   <= lat_q + SUM_W'(cfg_mem_lat);
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_valid = (state_q == ST_DONE);
    assign done_lat   = lat_q;

    cachelat_total #(.IN_W(SUM_W), .TOT_W(TOT_W)) total_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_case),
        .add_en  (done_valid),
        .add_val (done_lat),
        .total   (total_lat)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_lat >= SUM_W'(cfg_lat[LAT_W-1:0]))); // R2
    AST_CLEAR_TOTAL: assert property (@(posedge clk) disable iff (rst)
        start_case |=> (total_lat == '0)); // R9
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROBE) |-> (ctx_q.lvl <= last_lvl)); // R10
endmodule

// File: tb/cachelat_top_tb_top.sv
module cachelat_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB  = 8;
    localparam int LATW  = 16;
    localparam int TOTW  = 32;
    localparam int CNTW  = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_case = 1'b0;
    logic [1:0]      cfg_levels = 2'd2;
    logic [11:0]     cfg_blk_log2 = '0;
    logic [3*CNTW-1:0] cfg_blocks = '0;
    logic [3*LATW-1:0] cfg_lat = '0;
    logic [LATW-1:0] cfg_mem_lat = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [15:0]     req_addr = '0;
    logic            done_valid;
    logic [LATW+1:0] done_lat;
    logic [TOTW-1:0] total_lat;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cachelat_top #(.MAX_BLOCKS(MAXB), .LAT_W(LATW), .TOT_W(TOTW)) dut_i (
        .clk, .rst, .start_case, .cfg_levels, .cfg_blk_log2, .cfg_blocks,
        .cfg_lat, .cfg_mem_lat, .req_valid, .req_ready, .req_addr,
        .done_valid, .done_lat, .total_lat
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0", cycles);
            summary();
        end
    end

    task automatic set_cfg(input int lv, input int s0, s1, s2,
                           input int b0, b1, b2, input int l0, l1, l2, input int mem);
        cfg_levels   = 2'(lv);
        cfg_blk_log2 = {4'(s2), 4'(s1), 4'(s0)};
        cfg_blocks   = {CNTW'(b2), CNTW'(b1), CNTW'(b0)};
        cfg_lat      = {LATW'(l2), LATW'(l1), LATW'(l0)};
        cfg_mem_lat  = LATW'(mem);
    endtask

    task automatic new_case;
        @(negedge clk);
        start_case = 1'b1;
        @(posedge clk);
        #1 start_case = 1'b0;
        @(negedge clk);
        check("R9 total cleared", total_lat, 0);
    endtask

    // Issue a read; when collide is set, start_case rides on the done cycle.
    task automatic do_read(input string req, input int addr, input int exp, input bit collide);
        int n = 0;
        @(negedge clk);
        req_addr  = 16'(addr);
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check("R1 ready low while busy", req_ready, 0);
        while (!done_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(req, done_lat, exp);
        if (collide) start_case = 1'b1;
        @(posedge clk);
        #1 start_case = 1'b0;
        @(negedge clk);
        check("R1 single done pulse", done_valid, 0);
    endtask

    task automatic test_reset;
        check("R11 ready after reset", req_ready, 1);
        check("R11 done low after reset", done_valid, 0);
        check("R11 total zero after reset", total_lat, 0);
    endtask

    task automatic test_two_level_a;
        set_cfg(2, 4, 5, 0, 2, 2, 0, 4, 10, 0, 50);
        new_case();
        do_read("R3 miss all", 10, 64, 0);
        do_read("R2 hit L2", 20, 14, 0);
        do_read("R8 hit L1 after fill", 30, 4, 0);
        do_read("R6 evict LRU miss", 40, 64, 0);
        do_read("R2 hit L2 after evict", 50, 14, 0);
        check("R9 total case A", total_lat, 160);
    endtask

    task automatic test_two_level_b;
        set_cfg(2, 3, 5, 0, 6, 2, 0, 4, 10, 0, 50);
        new_case();
        do_read("R9 empty after start", 10, 64, 0);
        do_read("R2 L2 hit b1", 20, 14, 0);
        do_read("R2 L2 hit b2", 30, 14, 0);
        do_read("R3 miss b", 40, 64, 0);
        do_read("R2 L2 hit b3", 50, 14, 0);
        check("R9 total case B", total_lat, 170);
    endtask

    task automatic test_one_level;
        set_cfg(1, 4, 0, 0, 2, 0, 0, 4, 0, 0, 50);
        new_case();
        do_read("R10 one level miss", 0, 54, 0);
        do_read("R4 same block hit", 5, 4, 0);
        do_read("R10 second block", 16, 54, 0);
        do_read("R7 hit refreshes", 0, 4, 0);
        do_read("R6 evict oldest", 32, 54, 0);
        do_read("R7 refreshed block kept", 0, 4, 0);
        do_read("R6 evicted block misses", 16, 54, 0);
    endtask

    task automatic test_three_level;
        set_cfg(3, 2, 4, 6, 4, 2, 2, 1, 3, 7, 20);
        new_case();
        do_read("R10 three level miss", 0, 31, 0);
        do_read("R2 hit L2", 4, 4, 0);
        do_read("R2 hit L3", 16, 11, 0);
        do_read("R3 three level miss", 64, 31, 0);
        do_read("R5 free slots kept", 1, 1, 0);
        do_read("R5 second kept", 5, 1, 0);
        do_read("R4 aligned hit", 2, 1, 0);
        check("R9 total three", total_lat, 80);
    endtask

    task automatic test_collision;
        do_read("R2 hit before clear", 3, 1, 1);
        check("R9 clear beats add", total_lat, 0);
        do_read("R9 levels emptied on done", 3, 31, 0);
        check("R9 total after clear", total_lat, 31);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_two_level_a();
        test_two_level_b();
        test_one_level();
        test_three_level();
        test_collision();
        summary();
    end
endmodule